// File: doc/BRIEF.md
# Multi-Core Power-Domain Sequencer

This block brings one CPU core of a small cluster up or down. It steps through a fixed order of control actions on that core's power switch, isolation clamp, clock enable, four reset request lines and wake-on-interrupt mask. It waits a timed settle interval after the steps that need one. A requester gives a one-cycle start pulse, a core index and a direction. It watches a busy level and a one-cycle done pulse. All other cores keep their control outputs frozen while a sequence runs.

Only some cores sit in a power domain that can be switched off. The set is chosen by a mask parameter, and by default it is cores 2 and 3. Those cores also have an isolation clamp. On the other cores the power-switch and isolation actions do nothing, and so do the short waits tied to isolation. The long settle wait after the power-on step is still taken on every core. The settle times are given in microseconds. They become cycle counts from a clock-frequency parameter given in kHz, and a single shared down-counter times them.

The power-up order has two reset phases. First the core, SIMD and debug resets are released. All four resets are then driven back on together with the performance-monitor reset. Later all four are released in the same cycle. This gives each core a short reset pulse before the final release.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, busy and done are low. Core 0 is powered, not isolated, clocked, with all four resets released and its mask clear. Core 1 is powered and not isolated, with clock off, all resets on and mask set. Cores 2 and 3 are unpowered and isolated, with clock off, all resets on and mask set.
- R2: Power-up of a switchable core performs, in order: power on, long wait, clock on, release core/SIMD/debug resets, assert all four resets, remove isolation, short wait, clear mask, release all four resets in one cycle.
- R3: Power-up of a core outside the switchable set leaves power and isolation unchanged, still takes the long wait after the power-on step, and takes no short wait.
- R4: Power-down of a switchable core performs, in order: set mask, clock off, apply isolation, short wait, assert all four resets, power off, long wait, then finish.
- R5: Power-down of a core outside the switchable set performs set mask, clock off, assert all four resets, with no wait and no change to power or isolation.
- R6: The long wait is CLK_KHZ*PWR_SETTLE_US/1000 cycles and the short wait is CLK_KHZ*ISO_SETTLE_US/1000 cycles (at least 1). The action after a wait comes no fewer cycles than that after the action before it.
- R7: busy rises in the cycle after an accepted start. done is high for exactly one cycle, the last cycle of busy. busy is low in the cycle after done.
- R8: A start pulse while busy is high is ignored: the running sequence keeps its core, and the requested core's outputs do not change.
- R9: The outputs of every core other than the one being sequenced hold their values for the whole sequence.
- R10: A switchable core is never unpowered without isolation, and no core has its clock enabled while unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to sequence a core |
| core_sel_i | input | IDX_W | Index of the core to sequence |
| power_up_i | input | 1 | 1 = power up, 0 = power down |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| pwr_on_o | output | NUM_CORES | Power switch on, per core |
| iso_on_o | output | NUM_CORES | Isolation clamp applied, per core |
| clk_en_o | output | NUM_CORES | Core clock enable, per core |
| rst_cpu_o | output | NUM_CORES | Core reset request, per core |
| rst_simd_o | output | NUM_CORES | SIMD unit reset request, per core |
| rst_dbg_o | output | NUM_CORES | Debug logic reset request, per core |
| rst_perf_o | output | NUM_CORES | Performance-monitor reset request, per core |
| wfi_mask_o | output | NUM_CORES | Wake-on-interrupt mask, per core |

## Verification
If the step state is corrupted, it shows at the ports at the next clock edge. One of the eight per-core control bits changes out of order, or changes on a core that is not selected. The scoreboard compares every change of the selected core's control word, in order, against an expected list. It also checks the cycle gap since the previous change against the settle bounds. A fault in the settle counter shows only as a gap that is too short or too long, when the following action lands. A fault in busy or done shows within one cycle of the start pulse or the final step.

// File: rtl/core_pwr_seq_pkg.sv
package core_pwr_seq_pkg;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_PWR_ON,
    ACT_CLK_ON,
    ACT_REL_PARTIAL,
    ACT_RST_ALL,
    ACT_ISO_OFF,
    ACT_MASK_CLR,
    ACT_REL_ALL,
    ACT_MASK_SET,
    ACT_CLK_OFF,
    ACT_ISO_ON,
    ACT_PWR_OFF
  } seq_act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_PWR,
    ST_UP_CLK,
    ST_UP_REL3,
    ST_UP_RST,
    ST_UP_ISO,
    ST_UP_MASK,
    ST_UP_REL,
    ST_DN_MASK,
    ST_DN_CLK,
    ST_DN_ISO,
    ST_DN_RST,
    ST_DN_PWR,
    ST_WAIT,
    ST_FINISH
  } seq_state_e;

  typedef struct packed {
    logic pwr;
    logic iso;
    logic clk;
    logic rst_cpu;
    logic rst_simd;
    logic rst_dbg;
    logic rst_perf;
    logic wfi_mask;
  } core_ctl_t;

  // Settle time in microseconds to clock cycles, never below one cycle.
  function automatic int unsigned settle_cycles(input int unsigned clk_khz,
                                                input int unsigned us);
    int unsigned r;
    r = (clk_khz * us) / 1000;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/core_pwr_seq_timer.sv
module core_pwr_seq_timer #(
  parameter int CNT_W   = 13,
  parameter int MAX_LEN = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LEN));

  assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> expired_o);

endmodule

// File: rtl/core_pwr_seq_fsm.sv
module core_pwr_seq_fsm
  import core_pwr_seq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 13,
  parameter int LONG_CYC  = 5000,
  parameter int SHORT_CYC = 50,
  parameter logic [NUM_CORES-1:0] SWITCHED_MASK = 4'b1100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] core_sel_i,
  input  logic             power_up_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output seq_act_e         act_o,
  output logic [IDX_W-1:0] act_core_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_state_e       state_q, state_d;
  seq_state_e       ret_q, ret_d;
  logic [IDX_W-1:0] core_q;
  logic             switched;

  assign switched = SWITCHED_MASK[core_q];

  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    act_o      = ACT_NONE;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = power_up_i ? ST_UP_PWR : ST_DN_MASK;
      ST_UP_PWR: begin
        act_o      = ACT_PWR_ON;
        tmr_load_o = 1'b1;
        tmr_len_o  = CNT_W'(LONG_CYC);
        ret_d      = ST_UP_CLK;
        state_d    = ST_WAIT;
      end
      ST_UP_CLK: begin
        act_o   = ACT_CLK_ON;
        state_d = ST_UP_REL3;
      end
      ST_UP_REL3: begin
        act_o   = ACT_REL_PARTIAL;
        state_d = ST_UP_RST;
      end
      ST_UP_RST: begin
        act_o   = ACT_RST_ALL;
        state_d = ST_UP_ISO;
      end
      ST_UP_ISO: begin
        act_o = ACT_ISO_OFF;
        if (switched) begin
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(SHORT_CYC);
          ret_d      = ST_UP_MASK;
          state_d    = ST_WAIT;
        end else begin
          state_d = ST_UP_MASK;
        end
      end
      ST_UP_MASK: begin
        act_o   = ACT_MASK_CLR;
        state_d = ST_UP_REL;
      end
      ST_UP_REL: begin
        act_o   = ACT_REL_ALL;
        state_d = ST_FINISH;
      end
      ST_DN_MASK: begin
        act_o   = ACT_MASK_SET;
        state_d = ST_DN_CLK;
      end
      ST_DN_CLK: begin
        act_o   = ACT_CLK_OFF;
        state_d = ST_DN_ISO;
      end
      ST_DN_ISO: begin
        act_o = ACT_ISO_ON;
        if (switched) begin
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(SHORT_CYC);
          ret_d      = ST_DN_RST;
          state_d    = ST_WAIT;
        end else begin
          state_d = ST_DN_RST;
        end
      end
      ST_DN_RST: begin
        act_o   = ACT_RST_ALL;
        state_d = ST_DN_PWR;
      end
      ST_DN_PWR: begin
        act_o = ACT_PWR_OFF;
        if (switched) begin
          tmr_load_o = 1'b1;
          tmr_len_o  = CNT_W'(LONG_CYC);
          ret_d      = ST_FINISH;
          state_d    = ST_WAIT;
        end else begin
          state_d = ST_FINISH;
        end
      end
      ST_WAIT:    if (tmr_expired_i) state_d = ret_q;
      ST_FINISH:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      core_q  <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (state_q == ST_IDLE && start_i) core_q <= core_sel_i;
    end
  end

  assign act_core_o = core_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FINISH);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(core_q));

endmodule

// File: rtl/core_pwr_seq_bank.sv
module core_pwr_seq_bank
  import core_pwr_seq_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  parameter logic [NUM_CORES-1:0] SWITCHED_MASK = 4'b1100,
  parameter logic [NUM_CORES-1:0] RUN_MASK      = 4'b0001
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seq_act_e                    act_i,
  input  logic [IDX_W-1:0]            act_core_i,
  output core_ctl_t [NUM_CORES-1:0]   ctl_o
);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam logic SW  = SWITCHED_MASK[g];
    localparam logic RUN = RUN_MASK[g];
    core_ctl_t ctl_q;
    logic      hit;

    assign hit = (act_i != ACT_NONE) && (act_core_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q.pwr      <= !SW;
        ctl_q.iso      <= SW;
        ctl_q.clk      <= RUN;
        ctl_q.rst_cpu  <= !RUN;
        ctl_q.rst_simd <= !RUN;
        ctl_q.rst_dbg  <= !RUN;
        ctl_q.rst_perf <= !RUN;
        ctl_q.wfi_mask <= !RUN;
      end else if (hit) begin
        case (act_i)
          ACT_PWR_ON:  if (SW) ctl_q.pwr <= 1'b1;
          ACT_PWR_OFF: if (SW) ctl_q.pwr <= 1'b0;
          ACT_ISO_ON:  if (SW) ctl_q.iso <= 1'b1;
          ACT_ISO_OFF: if (SW) ctl_q.iso <= 1'b0;
          ACT_CLK_ON:  ctl_q.clk <= 1'b1;
          ACT_CLK_OFF: ctl_q.clk <= 1'b0;
          ACT_REL_PARTIAL: begin
            ctl_q.rst_cpu  <= 1'b0;
            ctl_q.rst_simd <= 1'b0;
            ctl_q.rst_dbg  <= 1'b0;
          end
          ACT_RST_ALL: begin
            ctl_q.rst_cpu  <= 1'b1;
            ctl_q.rst_simd <= 1'b1;
            ctl_q.rst_dbg  <= 1'b1;
            ctl_q.rst_perf <= 1'b1;
          end
          ACT_REL_ALL: begin
            ctl_q.rst_cpu  <= 1'b0;
            ctl_q.rst_simd <= 1'b0;
            ctl_q.rst_dbg  <= 1'b0;
            ctl_q.rst_perf <= 1'b0;
          end
          ACT_MASK_SET: ctl_q.wfi_mask <= 1'b1;
          ACT_MASK_CLR: ctl_q.wfi_mask <= 1'b0;
          default: ;
        endcase
      end
    end

    assign ctl_o[g] = ctl_q;
  end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_seq_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int IDX_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  parameter int CLK_KHZ       = 50_000,
  parameter int PWR_SETTLE_US = 100,
  parameter int ISO_SETTLE_US = 1,
  parameter logic [NUM_CORES-1:0] SWITCHED_MASK = 4'b1100,
  parameter logic [NUM_CORES-1:0] RUN_MASK      = 4'b0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     core_sel_i,
  input  logic                 power_up_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_CORES-1:0] pwr_on_o,
  output logic [NUM_CORES-1:0] iso_on_o,
  output logic [NUM_CORES-1:0] clk_en_o,
  output logic [NUM_CORES-1:0] rst_cpu_o,
  output logic [NUM_CORES-1:0] rst_simd_o,
  output logic [NUM_CORES-1:0] rst_dbg_o,
  output logic [NUM_CORES-1:0] rst_perf_o,
  output logic [NUM_CORES-1:0] wfi_mask_o
);

  localparam int LONG_CYC  = int'(settle_cycles(CLK_KHZ, PWR_SETTLE_US));
  localparam int SHORT_CYC = int'(settle_cycles(CLK_KHZ, ISO_SETTLE_US));
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic                      tmr_load, tmr_expired;
  logic [CNT_W-1:0]          tmr_len;
  seq_act_e                  act;
  logic [IDX_W-1:0]          act_core;
  core_ctl_t [NUM_CORES-1:0] ctl;

  core_pwr_seq_fsm #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .SWITCHED_MASK(SWITCHED_MASK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_sel_i(core_sel_i),
    .power_up_i(power_up_i), .tmr_expired_i(tmr_expired), .tmr_load_o(tmr_load),
    .tmr_len_o(tmr_len), .act_o(act), .act_core_o(act_core),
    .busy_o(busy_o), .done_o(done_o)
  );

  core_pwr_seq_timer #(.CNT_W(CNT_W), .MAX_LEN(MAX_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len),
    .expired_o(tmr_expired)
  );

  core_pwr_seq_bank #(
    .NUM_CORES(NUM_CORES), .IDX_W(IDX_W),
    .SWITCHED_MASK(SWITCHED_MASK), .RUN_MASK(RUN_MASK)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .act_i(act), .act_core_i(act_core), .ctl_o(ctl)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_out
    assign pwr_on_o[g]   = ctl[g].pwr;
    assign iso_on_o[g]   = ctl[g].iso;
    assign clk_en_o[g]   = ctl[g].clk;
    assign rst_cpu_o[g]  = ctl[g].rst_cpu;
    assign rst_simd_o[g] = ctl[g].rst_simd;
    assign rst_dbg_o[g]  = ctl[g].rst_dbg;
    assign rst_perf_o[g] = ctl[g].rst_perf;
    assign wfi_mask_o[g] = ctl[g].wfi_mask;

    assert_iso_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on_o[g] |-> iso_on_o[g]);

    assert_clk_needs_pwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o[g] |-> pwr_on_o[g]);

    assert_mask_after_iso_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wfi_mask_o[g] |-> !iso_on_o[g]);

    assert_perf_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_perf_o[g] |-> !(rst_cpu_o[g] || rst_simd_o[g] || rst_dbg_o[g]));

    assert_others_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && act_core != IDX_W'(g)) |=> $stable(ctl[g]));
  end

endmodule

// File: tb/test_core_pwr_seq.sv
module test_core_pwr_seq;

  localparam int NC         = 4;
  localparam int CYC_PER_US = 50;               // 50 MHz clock
  localparam int LONG       = 100 * CYC_PER_US;
  localparam int SHORT      = 1 * CYC_PER_US;
  localparam logic [NC-1:0] SW_SET = 4'b1100;

  // control word bit positions: 7 pwr,6 iso,5 clk,4 cpu,3 simd,2 dbg,1 perf,0 mask
  localparam int K_PWR_ON = 0, K_CLK_ON = 1, K_REL3 = 2, K_RST_ALL = 3, K_ISO_OFF = 4,
                 K_MASK_CLR = 5, K_REL_ALL = 6, K_MASK_SET = 7, K_CLK_OFF = 8,
                 K_ISO_ON = 9, K_PWR_OFF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, up = 1'b0;
  logic [1:0] sel = '0;
  logic busy, done;
  logic [NC-1:0] pwr_on, iso_on, clk_en, r_cpu, r_simd, r_dbg, r_perf, wmask;

  core_pwr_seq i_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .core_sel_i(sel), .power_up_i(up),
    .busy_o(busy), .done_o(done), .pwr_on_o(pwr_on), .iso_on_o(iso_on),
    .clk_en_o(clk_en), .rst_cpu_o(r_cpu), .rst_simd_o(r_simd), .rst_dbg_o(r_dbg),
    .rst_perf_o(r_perf), .wfi_mask_o(wmask)
  );

  always #10 clk = ~clk;

  typedef struct { logic [7:0] snap; int mn; int mx; } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0, cyc = 0, last_stamp = 0, done_cnt = 0;
  int act_core = -1;
  bit mon_on = 1'b0;
  string cur_req = "R1";
  logic [7:0] model[NC];
  logic [7:0] seen[NC];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] live(int i);
    return {pwr_on[i], iso_on[i], clk_en[i], r_cpu[i], r_simd[i], r_dbg[i], r_perf[i], wmask[i]};
  endfunction

  task automatic check(bit ok, string req, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  // Scoreboard monitor: every change of a core's control word is matched.
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) done_cnt++;
      for (int i = 0; i < NC; i++) begin
        logic [7:0] l;
        l = live(i);
        if (l != seen[i]) begin
          if (i == act_core && q.size() > 0) begin
            exp_t e;
            int gap;
            e = q.pop_front();
            gap = cyc - last_stamp;
            check(l == e.snap, cur_req, $sformatf("core%0d step word", i), int'(l), int'(e.snap));
            check(gap >= e.mn && gap <= e.mx, "R6", $sformatf("core%0d step gap (min %0d max %0d)", i, e.mn, e.mx), gap, e.mn);
            last_stamp = cyc;
          end else begin
            check(1'b0, (i == act_core) ? cur_req : "R9", $sformatf("unexpected change core%0d", i), int'(l), int'(seen[i]));
          end
          seen[i] = l;
        end
      end
    end
  end

  task automatic add_step(int c, int kind, int wait_len, inout int mn, inout int mx);
    logic [7:0] m;
    bit sw;
    sw = SW_SET[c];
    m = model[c];
    case (kind)
      K_PWR_ON:   if (sw) m[7] = 1'b1;
      K_PWR_OFF:  if (sw) m[7] = 1'b0;
      K_ISO_ON:   if (sw) m[6] = 1'b1;
      K_ISO_OFF:  if (sw) m[6] = 1'b0;
      K_CLK_ON:   m[5] = 1'b1;
      K_CLK_OFF:  m[5] = 1'b0;
      K_REL3:     m[4:2] = 3'b000;
      K_RST_ALL:  m[4:1] = 4'b1111;
      K_REL_ALL:  m[4:1] = 4'b0000;
      K_MASK_SET: m[0] = 1'b1;
      K_MASK_CLR: m[0] = 1'b0;
      default: ;
    endcase
    mn += 1;
    mx += 1;
    if (m != model[c]) begin
      q.push_back('{snap: m, mn: mn, mx: mx});
      mn = 0;
      mx = 0;
    end
    model[c] = m;
    if (wait_len > 0) begin
      mn += wait_len;
      mx += wait_len + 2;
    end
  endtask

  task automatic run_seq(int c, bit dir_up, string req, int intruder);
    int mn, mx, base, t;
    bit sw;
    sw = SW_SET[c];
    mn = 0;
    mx = 4;
    q.delete();
    if (dir_up) begin
      add_step(c, K_PWR_ON, LONG, mn, mx);
      add_step(c, K_CLK_ON, 0, mn, mx);
      add_step(c, K_REL3, 0, mn, mx);
      add_step(c, K_RST_ALL, 0, mn, mx);
      add_step(c, K_ISO_OFF, sw ? SHORT : 0, mn, mx);
      add_step(c, K_MASK_CLR, 0, mn, mx);
      add_step(c, K_REL_ALL, 0, mn, mx);
    end else begin
      add_step(c, K_MASK_SET, 0, mn, mx);
      add_step(c, K_CLK_OFF, 0, mn, mx);
      add_step(c, K_ISO_ON, sw ? SHORT : 0, mn, mx);
      add_step(c, K_RST_ALL, 0, mn, mx);
      add_step(c, K_PWR_OFF, sw ? LONG : 0, mn, mx);
    end
    base = done_cnt;
    cur_req = req;
    act_core = c;
    @(negedge clk);
    start = 1'b1; sel = 2'(c); up = dir_up;
    last_stamp = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    if (intruder >= 0) begin
      repeat (200) @(negedge clk);
      start = 1'b1; sel = 2'(intruder); up = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R8", "busy after ignored start", int'(busy), 1);
    end
    t = 0;
    while (!done && t < 3 * LONG) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, req, "done reached", int'(done), 1);
    check(busy == 1'b1, "R7", "busy during done", int'(busy), 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done one cycle then idle", int'({done, busy}), 0);
    check(done_cnt == base + 1, "R7", "done pulse count", done_cnt - base, 1);
    check(q.size() == 0, req, "all steps observed", q.size(), 0);
    check(live(c) == model[c], req, "final word", int'(live(c)), int'(model[c]));
    act_core = -1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model[0] = 8'b1010_0000;
    model[1] = 8'b1001_1111;
    model[2] = 8'b0101_1111;
    model[3] = 8'b0101_1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset", int'({busy, done}), 0);
    for (int i = 0; i < NC; i++) begin
      check(live(i) == model[i], "R1", $sformatf("core%0d reset word", i), int'(live(i)), int'(model[i]));
      seen[i] = live(i);
    end
    mon_on = 1'b1;

    run_seq(2, 1'b1, "R2", -1);  // switchable core up
    run_seq(1, 1'b1, "R3", -1);  // non-switchable core up, long wait kept
    run_seq(1, 1'b0, "R5", -1);  // non-switchable core down
    run_seq(2, 1'b0, "R4", 3);   // switchable down, with ignored start for core 3
    check(live(3) == model[3], "R8", "core3 untouched by ignored start", int'(live(3)), int'(model[3]));
    run_seq(3, 1'b1, "R2", -1);
    run_seq(0, 1'b0, "R5", -1);
    run_seq(0, 1'b1, "R3", -1);
    check(live(2) == model[2] && live(1) == model[1], "R9", "idle cores held", int'(live(2)), int'(model[2]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule